// File: doc/BRIEF.md
# Converter Output Test Word Generator

This block sits between a 12-bit converter's parallel sample bus and the pins that carry it off chip. In normal operation it forwards each live sample, registered once in the sample clock domain. When a test pattern is selected, it replaces the live samples with fixed words or with two software-defined 16-bit words. The words may be held static or may alternate on successive sample cycles, so a receiver can check the data path in the field without a signal source.

Settings arrive through a simple byte-wide register-write port clocked by a configuration clock that is unrelated to the sample clock. One control byte holds a 4-bit pattern code and a 2-bit user-mode field. Four byte registers hold the low and high halves of the two user words. Every setting crosses into the sample domain through a two-flop synchronizer, so a new pattern shows up a few sample cycles after the write. Each 16-bit test word is cut down to its upper 12 bits for the bus.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While rst_ni is low, data_o is 0 and all settings clear. After reset the pattern code is 0000, so live data is forwarded.
- R2: With pattern code 0000, data_o equals the adc_data_i value captured at the previous sample clock edge.
- R3: Code 0001 drives 0x800 (midscale 0x8000). Code 0010 drives 0xFFF (0xFFFF). Code 0011 drives 0x000 (0x0000). Each value is constant on every cycle.
- R4: Code 0100 drives a checkerboard that alternates 0xAAA and 0x555 (from 0xAAAA and 0x5555) on successive cycles. The first test word after any control change is 0xAAA.
- R5: Code 0111 alternates 0xFFF and 0x000 on successive cycles.
- R6: Code 1000 with user mode 00 drives word 1 on every cycle. Word 1 is {byte at address 2, byte at address 1}, and its upper 12 bits go out.
- R7: Code 1000 with user mode 01 alternates word 1 and word 2. Word 2 is {byte at address 4, byte at address 3}. The first test word after the control change is word 1.
- R8: The reserved codes (0101, 0110 and 1001 to 1111) forward live data exactly as code 0000 does.
- R9: User modes 10 and 11 behave as static mode 00.
- R10: A control write at address 0 takes the pattern code from wdata bits [3:0] and the user mode from bits [5:4]. The new output appears within 4 sample clock cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk_i | input | 1 | Configuration write clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| cfg_we_i | input | 1 | Write strobe for the register port |
| cfg_addr_i | input | 3 | Register address (0 control, 1 to 4 user word bytes) |
| cfg_wdata_i | input | 8 | Write data byte |
| smp_clk_i | input | 1 | Sample clock |
| adc_data_i | input | 12 | Live converter sample |
| data_o | output | 12 | Output sample bus |

## Verification
Live forwarding has one cycle of latency. The bench changes adc_data_i just after a falling sample edge and reads data_o at the next falling edge, after exactly one register. A setting change passes through the configuration register, two sync stages and the output register. The bench therefore counts sample cycles from the end of a write until data_o moves and requires at most 4. Steady-state values are read only after a settle time of six sample cycles. The first word after a change is found by waiting for data_o to leave a known live value. For this the bench changes only one control bit at a time, so that no intermediate code can show up.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int PAT_W  = 4;
  localparam int UM_W   = 2;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [PAT_W-1:0] PAT_OFF  = 4'b0000;
  localparam logic [PAT_W-1:0] PAT_MID  = 4'b0001;
  localparam logic [PAT_W-1:0] PAT_POS  = 4'b0010;
  localparam logic [PAT_W-1:0] PAT_NEG  = 4'b0011;
  localparam logic [PAT_W-1:0] PAT_CKB  = 4'b0100;
  localparam logic [PAT_W-1:0] PAT_ONEZ = 4'b0111;
  localparam logic [PAT_W-1:0] PAT_USER = 4'b1000;

  localparam logic [UM_W-1:0] UM_ALT = 2'b01;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_W1_LO = 3'd1;
  localparam logic [2:0] A_W1_HI = 3'd2;
  localparam logic [2:0] A_W2_LO = 3'd3;
  localparam logic [2:0] A_W2_HI = 3'd4;

  typedef struct packed {
    logic [UM_W-1:0]  umode;
    logic [PAT_W-1:0] pat;
  } ctrl_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic [WORD_W-1:0] w2;
    logic [WORD_W-1:0] w1;
  } cfg_t;

  typedef struct packed {
    logic              live;
    logic              alt;
    logic [WORD_W-1:0] wa;
    logic [WORD_W-1:0] wb;
  } sel_t;

  function automatic sel_t decode(cfg_t c);
    sel_t s;
    s = '{live: 1'b0, alt: 1'b0, wa: '0, wb: '0};
    unique case (c.ctrl.pat)
      PAT_MID:  s.wa = 16'h8000;
      PAT_POS:  s.wa = 16'hFFFF;
      PAT_NEG:  s.wa = 16'h0000;
      PAT_CKB:  begin s.wa = 16'hAAAA; s.wb = 16'h5555; s.alt = 1'b1; end
      PAT_ONEZ: begin s.wa = 16'hFFFF; s.wb = 16'h0000; s.alt = 1'b1; end
      PAT_USER: begin
        s.wa  = c.w1;
        s.wb  = c.w2;
        s.alt = (c.ctrl.umode == UM_ALT);
      end
      default:  s.live = 1'b1; // off and reserved codes
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tpg_cfg_regs.sv
module tpg_cfg_regs
  import tpg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output cfg_t              cfg_o
);
  localparam int NBYTES = WORD_W / BYTE_W;

  cfg_t cfg_q;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[BYTE_W-1:PAT_W+UM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(A_CTRL): begin
          cfg_q.ctrl.pat   <= wdata_i[PAT_W-1:0];
          cfg_q.ctrl.umode <= wdata_i[PAT_W+UM_W-1:PAT_W];
        end
        ADDR_W'(A_W1_LO): cfg_q.w1[BYTE_W-1:0]      <= wdata_i;
        ADDR_W'(A_W1_HI): cfg_q.w1[WORD_W-1:BYTE_W] <= wdata_i;
        ADDR_W'(A_W2_LO): cfg_q.w2[BYTE_W-1:0]      <= wdata_i;
        ADDR_W'(A_W2_HI): cfg_q.w2[WORD_W-1:BYTE_W] <= wdata_i;
        default: ;
      endcase
    end
  end

  initial begin
    if (NBYTES != 2) $error("word must be two bytes");
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tpg_sync.sv
module tpg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tpg_core.sv
module tpg_core
  import tpg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_t              cfg_i,
  input  logic [DATA_W-1:0] adc_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int LOW_W = WORD_W - DATA_W;

  ctrl_t             ctrl_d1_q;
  logic              phase_q;
  logic              ctrl_chg;
  logic              phase_eff;
  sel_t              sel;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] data_q;

  assign ctrl_chg  = (cfg_i.ctrl != ctrl_d1_q);
  // restart on word 1 whenever the mode moves
  assign phase_eff = ctrl_chg ? 1'b0 : phase_q;
  assign sel       = decode(cfg_i);
  assign word      = (sel.alt && phase_eff) ? sel.wb : sel.wa;
  assign nxt       = sel.live ? adc_i : word[WORD_W-1 -: DATA_W];

  generate
    if (LOW_W > 0) begin : g_trunc
      logic unused_low;
      assign unused_low = ^word[LOW_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_d1_q <= '0;
      phase_q   <= 1'b0;
      data_q    <= '0;
    end else begin
      ctrl_d1_q <= cfg_i.ctrl;
      phase_q   <= ~phase_eff;
      data_q    <= nxt;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cfg_clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              smp_clk_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t cfg_q;
  cfg_t cfg_s;

  tpg_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i  (cfg_clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg_q)
  );

  tpg_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (smp_clk_i),
    .rst_ni(rst_ni),
    .d_i   (cfg_q),
    .q_o   (cfg_s)
  );

  tpg_core #(.DATA_W(DATA_W)) u_core (
    .clk_i (smp_clk_i),
    .rst_ni(rst_ni),
    .cfg_i (cfg_s),
    .adc_i (adc_data_i),
    .data_o(data_o)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PAT_W-1:0]  pat_i,
  input logic [UM_W-1:0]   umode_i,
  input logic [DATA_W-1:0] w1_i,
  input logic [DATA_W-1:0] adc_i,
  input logic [DATA_W-1:0] data_i
);
  logic live_code;
  assign live_code = !(pat_i inside {PAT_MID, PAT_POS, PAT_NEG, PAT_CKB, PAT_ONEZ, PAT_USER});

  // R2, R8
  p_live_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_code |=> data_i == $past(adc_i));

  // R3
  p_midscale_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_i == PAT_MID |=> data_i == {1'b1, {(DATA_W-1){1'b0}}});

  // R4
  p_ckb_alt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_i == PAT_CKB && $stable(pat_i) && $stable(umode_i)) |=> data_i == ~$past(data_i));

  // R5
  p_onez_alt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_i == PAT_ONEZ && $stable(pat_i) && $stable(umode_i)) |=> data_i == ~$past(data_i));

  // R6, R9
  p_user_static_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_i == PAT_USER && umode_i != UM_ALT) |=> data_i == $past(w1_i));
endmodule

bind adc_test_pattern_gen tpg_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (smp_clk_i),
  .rst_ni (rst_ni),
  .pat_i  (cfg_s.ctrl.pat),
  .umode_i(cfg_s.ctrl.umode),
  .w1_i   (cfg_s.w1[15 -: DATA_W]),
  .adc_i  (adc_data_i),
  .data_i (data_o)
);

// File: tb/adc_test_pattern_gen_test.sv
`timescale 1ns/1ps
module adc_test_pattern_gen_test;
  localparam logic [11:0] LIVE = 12'h123;

  logic        cfg_clk = 1'b0;
  logic        smp_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [11:0] adc = LIVE;
  logic [11:0] dout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #7 cfg_clk = ~cfg_clk;
  always #5 smp_clk = ~smp_clk;

  adc_test_pattern_gen uut (
    .cfg_clk_i  (cfg_clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (we),
    .cfg_addr_i (addr),
    .cfg_wdata_i(wdata),
    .smp_clk_i  (smp_clk),
    .adc_data_i (adc),
    .data_o     (dout)
  );

  task automatic check(string req, logic [11:0] got, logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%03h exp=%03h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge cfg_clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge cfg_clk);
    we = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge smp_clk);
  endtask

  // wait until output leaves the live value; return first test word
  task automatic first_word(output logic [11:0] v);
    v = LIVE;
    for (int i = 0; i < 12; i++) begin
      @(negedge smp_clk);
      if (dout !== LIVE) begin v = dout; break; end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge smp_clk);
    check("R1 reset output", dout, 12'h000);
    @(negedge smp_clk);
    rst_n = 1'b1;
    settle();
    check("R1 default forwards live", dout, LIVE);
  endtask

  task automatic t_live();
    logic [11:0] vals [3] = '{12'hABC, 12'h001, 12'hF0F};
    foreach (vals[i]) begin
      adc = vals[i];
      @(negedge smp_clk);
      check("R2 live one cycle", dout, vals[i]);
    end
    adc = LIVE;
    @(negedge smp_clk);
  endtask

  task automatic t_const();
    int n;
    wr(3'd0, 8'h01);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge smp_clk);
      n++;
      if (dout === 12'h800) break;
    end
    total++;
    if (n > 4) begin
      bad++;
      $display("FAIL R10 latency got=%0d exp<=4", n);
    end
    settle();
    check("R3 midscale", dout, 12'h800);
    @(negedge smp_clk);
    check("R3 midscale held", dout, 12'h800);
    wr(3'd0, 8'h02); settle();
    check("R3 positive full scale", dout, 12'hFFF);
    wr(3'd0, 8'h03); settle();
    check("R3 negative full scale", dout, 12'h000);
    wr(3'd0, 8'h00); settle();
  endtask

  task automatic t_ckb();
    logic [11:0] v;
    wr(3'd0, 8'h04);
    first_word(v);
    check("R4 first word", v, 12'hAAA);
    for (int i = 0; i < 4; i++) begin
      @(negedge smp_clk);
      check("R4 checkerboard", dout, (i % 2 == 0) ? 12'h555 : 12'hAAA);
    end
    wr(3'd0, 8'h00); settle();
  endtask

  task automatic t_onez();
    logic [11:0] v;
    wr(3'd0, 8'h07); settle();
    v = dout;
    total++;
    if (v !== 12'hFFF && v !== 12'h000) begin
      bad++;
      $display("FAIL R5 value got=%03h exp=fff/000", v);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge smp_clk);
      check("R5 one/zero toggle", dout, ~v);
      v = dout;
    end
    wr(3'd0, 8'h00); settle();
  endtask

  task automatic t_user();
    logic [11:0] v;
    wr(3'd1, 8'h5A); wr(3'd2, 8'hC3);
    wr(3'd3, 8'h96); wr(3'd4, 8'h7E);
    wr(3'd0, 8'h08);
    first_word(v);
    check("R6 static word 1", v, 12'hC35);
    for (int i = 0; i < 4; i++) begin
      @(negedge smp_clk);
      check("R6 static held", dout, 12'hC35);
    end
    wr(3'd0, 8'h10); settle();
    check("R2 off with user mode set", dout, LIVE);
    wr(3'd0, 8'h18);
    first_word(v);
    check("R7 first word", v, 12'hC35);
    for (int i = 0; i < 4; i++) begin
      @(negedge smp_clk);
      check("R7 alternate", dout, (i % 2 == 0) ? 12'h7E9 : 12'hC35);
    end
    wr(3'd0, 8'h10); settle();
    wr(3'd0, 8'h00); settle();
    wr(3'd0, 8'h20); settle();
    wr(3'd0, 8'h28); settle();
    for (int i = 0; i < 3; i++) begin
      @(negedge smp_clk);
      check("R9 reserved mode static", dout, 12'hC35);
    end
    wr(3'd0, 8'h00); settle();
  endtask

  task automatic t_reserved();
    logic [7:0] codes [4] = '{8'h05, 8'h06, 8'h09, 8'h0F};
    foreach (codes[i]) begin
      wr(3'd0, codes[i]); settle();
      adc = 12'h3C0 + 12'(i);
      @(negedge smp_clk);
      check("R8 reserved code live", dout, 12'h3C0 + 12'(i));
      adc = LIVE;
    end
    wr(3'd0, 8'h00); settle();
  endtask

  initial begin
    t_reset();
    t_live();
    t_const();
    t_ckb();
    t_onez();
    t_user();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule